// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block is a hardware sequencer that reaches the 16-bit internal registers of a PHY whose registers sit outside the memory map. The only path into those registers is one 20-bit control word that the master drives and one 17-bit status word that the PHY returns. Every step of an access is a separate strobe. The PHY confirms each strobe by raising an acknowledge bit. The master drops the strobe only after the acknowledge rises, and it starts the next step only after the acknowledge falls again.

On the user side a caller presents an address, write data and a read/write select, and pulses a start input. One pulse later marks completion, together with an error flag and, for reads, the returned 16-bit value. Each wait for the acknowledge is bounded: the level is checked a fixed number of times with a programmable gap between checks. If the expected level never appears, the operation is abandoned and the control word returns to zero.

Top module: `phy_ctlport_master`

## Requirements
- R1: After reset, phy_ctrl is zero, req_done and req_err are low, and req_rdata is zero.
- R2: phy_ctrl[15:0] carries an address or data value. Bit 16 is capture-address, bit 17 is capture-data, bit 18 is write and bit 19 is read. At most one of bits 19:16 is high in any cycle. The acknowledge is phy_stat[16] and read data is phy_stat[15:0].
- R3: Every operation starts with this sequence on phy_ctrl: the address alone, then the address with capture-address until the acknowledge is high, then the address alone until the acknowledge is low.
- R4: A write then drives the data alone, then the data with capture-data until the acknowledge is high, then the data alone until the acknowledge is low.
- R5: A write ends by driving the write strobe alone (value field zero) until the acknowledge is high, then the data alone until the acknowledge is low, then all zeros. In that same cycle req_done pulses for exactly one cycle with req_err low.
- R6: After the address steps, a read drives the read strobe alone until the acknowledge is high and captures phy_stat[15:0]. It then drives zero until the acknowledge is low, and pulses req_done with req_err low and req_rdata holding the captured value.
- R7: Each wait checks the acknowledge, seen through a two-flop synchronizer, at most POLL_LIMIT times, with POLL_DELAY+1 cycles between checks. An acknowledge that arrives inside that window lets the operation complete normally.
- R8: If the last check of a wait misses, phy_ctrl goes to zero and req_done pulses with req_err high. No PHY write commit is issued. With the acknowledge never rising, req_done is high after the 3+(POLL_LIMIT-1)*(POLL_DELAY+1)-th rising edge, counting the edge that samples req_start as the first. The next operation then works normally.
- R9: req_start has no effect while an operation is in progress: the access runs with its original address, data and direction, and nothing starts after it.
- R10: While a wait is pending, phy_ctrl holds its value, so phy_ctrl changes only at the step boundaries listed in R3 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Starts an operation when the block is idle |
| req_write | input | 1 | 1 selects a write, 0 a read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Set when the completed operation timed out |
| req_rdata | output | 16 | Data returned by the last read |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
phy_ctrl is registered, so each step's value appears one edge after the step is decided. The acknowledge is used two edges after it changes at the port. The bench drives inputs and samples outputs on falling edges. It logs every change of phy_ctrl and compares the whole sequence to the expected one, rather than timing individual steps against a latency it would have to guess. The single exact timing check is the timeout: the bench counts rising edges from the start edge and requires req_done on the 3+(POLL_LIMIT-1)*(POLL_DELAY+1)-th edge. The one-cycle done pulse is confirmed on the falling edge that follows it.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;

    localparam int VAL_W   = 16;
    localparam int STB_W   = 4;
    localparam int CTRL_W  = VAL_W + STB_W;
    localparam int STAT_W  = VAL_W + 1;
    localparam int ACK_BIT = VAL_W;

    // strobe field, placed above the value field of the control word
    localparam logic [STB_W-1:0] STB_NONE    = 4'b0000;
    localparam logic [STB_W-1:0] STB_CAP_ADR = 4'b0001;
    localparam logic [STB_W-1:0] STB_CAP_DAT = 4'b0010;
    localparam logic [STB_W-1:0] STB_WR      = 4'b0100;
    localparam logic [STB_W-1:0] STB_RD      = 4'b1000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADR_SET, ST_ADR_HI, ST_ADR_LO,
        ST_DAT_SET, ST_DAT_HI, ST_DAT_LO,
        ST_WR_HI,   ST_WR_LO,
        ST_RD_HI,   ST_RD_LO
    } step_e;

    typedef struct packed {
        step_e             step;
        logic              is_wr;
        logic [VAL_W-1:0]  addr;
        logic [VAL_W-1:0]  wdata;
        logic [VAL_W-1:0]  rdata;
        logic [CTRL_W-1:0] ctrl;
        logic              done;
        logic              err;
    } mst_t;

    function automatic logic [CTRL_W-1:0] ctrl_word(input logic [STB_W-1:0] stb,
                                                    input logic [VAL_W-1:0] val);
        return {stb, val};
    endfunction

    // steps that sit in an acknowledge wait
    function automatic logic step_waits(input step_e s);
        return s inside {ST_ADR_HI, ST_ADR_LO, ST_DAT_HI, ST_DAT_LO,
                         ST_WR_HI, ST_WR_LO, ST_RD_HI, ST_RD_LO};
    endfunction

    // level of the acknowledge each waiting step expects
    function automatic logic step_wants_ack(input step_e s);
        return s inside {ST_ADR_HI, ST_DAT_HI, ST_WR_HI, ST_RD_HI};
    endfunction

endpackage

// File: rtl/phyctl_sync.sv
module phyctl_sync #(
    parameter int W      = 17,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[CHAIN_W-W-1:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/phyctl_poller.sv
module phyctl_poller #(
    parameter int POLL_DELAY = 100,
    parameter int POLL_LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic exp_lvl,
    input  logic ack,
    output logic hit,
    output logic miss
);
    localparam int DLY_W = (POLL_DELAY < 1) ? 1 : $clog2(POLL_DELAY + 1);
    localparam int CNT_W = (POLL_LIMIT < 2) ? 1 : $clog2(POLL_LIMIT);

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic [CNT_W-1:0] cnt;
    } pst_t;

    pst_t p_d, p_q;
    logic chk;

    always_comb begin
        chk  = run && (p_q.dly == '0);
        hit  = chk && (ack == exp_lvl);
        miss = chk && (ack != exp_lvl) && (p_q.cnt == CNT_W'(POLL_LIMIT - 1));

        p_d = p_q;
        if (!run || hit || miss) begin
            p_d = '0;
        end else if (chk) begin
            p_d.dly = DLY_W'(POLL_DELAY);
            p_d.cnt = p_q.cnt + 1'b1;
        end else begin
            p_d.dly = p_q.dly - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(p_q.cnt) < POLL_LIMIT); // R7

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (p_q == '0)); // R7

endmodule

// File: rtl/phy_ctlport_master.sv
module phy_ctlport_master
    import phyctl_pkg::*;
#(
    parameter int POLL_DELAY  = 100,
    parameter int POLL_LIMIT  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [VAL_W-1:0]  req_addr,
    input  logic [VAL_W-1:0]  req_wdata,
    output logic              req_done,
    output logic              req_err,
    output logic [VAL_W-1:0]  req_rdata,
    output logic [CTRL_W-1:0] phy_ctrl,
    input  logic [STAT_W-1:0] phy_stat
);
    logic [STAT_W-1:0] stat_s;
    logic waiting, exp_lvl, hit, miss;
    mst_t st_d, st_q;

    phyctl_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (phy_stat),
        .dout (stat_s)
    );

    assign waiting = step_waits(st_q.step);
    assign exp_lvl = step_wants_ack(st_q.step);

    phyctl_poller #(.POLL_DELAY(POLL_DELAY), .POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (waiting),
        .exp_lvl(exp_lvl),
        .ack    (stat_s[ACK_BIT]),
        .hit    (hit),
        .miss   (miss)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.step)
            ST_IDLE: begin
                if (req_start) begin
                    st_d.step  = ST_ADR_SET;
                    st_d.is_wr = req_write;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.err   = 1'b0;
                    st_d.ctrl  = ctrl_word(STB_NONE, req_addr);
                end
            end
            ST_ADR_SET: begin
                st_d.ctrl = ctrl_word(STB_CAP_ADR, st_q.addr);
                st_d.step = ST_ADR_HI;
            end
            ST_ADR_HI: if (hit) begin
                st_d.ctrl = ctrl_word(STB_NONE, st_q.addr);
                st_d.step = ST_ADR_LO;
            end
            ST_ADR_LO: if (hit) begin
                if (st_q.is_wr) begin
                    st_d.ctrl = ctrl_word(STB_NONE, st_q.wdata);
                    st_d.step = ST_DAT_SET;
                end else begin
                    st_d.ctrl = ctrl_word(STB_RD, '0);
                    st_d.step = ST_RD_HI;
                end
            end
            ST_DAT_SET: begin
                st_d.ctrl = ctrl_word(STB_CAP_DAT, st_q.wdata);
                st_d.step = ST_DAT_HI;
            end
            ST_DAT_HI: if (hit) begin
                st_d.ctrl = ctrl_word(STB_NONE, st_q.wdata);
                st_d.step = ST_DAT_LO;
            end
            ST_DAT_LO: if (hit) begin
                st_d.ctrl = ctrl_word(STB_WR, '0);
                st_d.step = ST_WR_HI;
            end
            ST_WR_HI: if (hit) begin
                st_d.ctrl = ctrl_word(STB_NONE, st_q.wdata);
                st_d.step = ST_WR_LO;
            end
            ST_WR_LO: if (hit) begin
                st_d.ctrl = '0;
                st_d.done = 1'b1;
                st_d.step = ST_IDLE;
            end
            ST_RD_HI: if (hit) begin
                st_d.rdata = stat_s[VAL_W-1:0];
                st_d.ctrl  = '0;
                st_d.step  = ST_RD_LO;
            end
            ST_RD_LO: if (hit) begin
                st_d.done = 1'b1;
                st_d.step = ST_IDLE;
            end
            default: begin
                st_d.ctrl = '0;
                st_d.step = ST_IDLE;
            end
        endcase
        if (miss) begin
            st_d.ctrl = '0;
            st_d.done = 1'b1;
            st_d.err  = 1'b1;
            st_d.step = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.step <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_done  = st_q.done;
    assign req_err   = st_q.err;
    assign req_rdata = st_q.rdata;
    assign phy_ctrl  = st_q.ctrl;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phy_ctrl[CTRL_W-1:VAL_W]) <= 1); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done); // R5

    AST_DONE_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> (phy_ctrl == '0)); // R8

    AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !hit && !miss) |=> $stable(phy_ctrl)); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step != ST_IDLE && req_start) |=> $stable(st_q.addr)); // R9

endmodule

// File: tb/phy_ctlport_master_bench.sv
module phy_ctlport_master_bench;
    import phyctl_pkg::*;

    localparam int DLY = 4;
    localparam int LIM = 10;
    localparam int TMO_EDGES = 3 + (LIM - 1) * (DLY + 1);

    // {write, addr, data, expected read data}
    localparam logic [48:0] VEC [8] = '{
        {1'b1, 16'h1005, 16'hA5A5, 16'h0000},
        {1'b1, 16'h0003, 16'h1234, 16'h0000},
        {1'b0, 16'h1005, 16'h0000, 16'hA5A5},
        {1'b0, 16'h0003, 16'h0000, 16'h1234},
        {1'b1, 16'hFFFF, 16'h0000, 16'h0000},
        {1'b0, 16'hFFFF, 16'h0000, 16'h0000},
        {1'b1, 16'h1005, 16'h0028, 16'h0000},
        {1'b0, 16'h1005, 16'h0000, 16'h0028}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              req_start = 1'b0;
    logic              req_write = 1'b0;
    logic [15:0]       req_addr  = '0;
    logic [15:0]       req_wdata = '0;
    logic              req_done, req_err;
    logic [15:0]       req_rdata;
    logic [CTRL_W-1:0] phy_ctrl;
    logic [STAT_W-1:0] phy_stat;

    phy_ctlport_master #(.POLL_DELAY(DLY), .POLL_LIMIT(LIM)) u_phy_ctlport_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_start(req_start),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_done (req_done),
        .req_err  (req_err),
        .req_rdata(req_rdata),
        .phy_ctrl (phy_ctrl),
        .phy_stat (phy_stat)
    );

    // PHY responder: 0 normal, 1 acknowledge never rises, 2 never falls
    int          resp_lat  = 3;
    int          resp_mode = 0;
    logic        r_ack;
    logic [15:0] r_adr, r_dat, r_rd;
    logic [15:0] mem [16];
    int          r_cnt;
    wire         want = |phy_ctrl[19:16];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_ack <= 1'b0; r_adr <= '0; r_dat <= '0; r_rd <= '0; r_cnt <= 0;
            for (int k = 0; k < 16; k++) mem[k] <= '0;
        end else if (want == r_ack) begin
            r_cnt <= 0;
        end else if ((want && resp_mode == 1) || (!want && resp_mode == 2)) begin
            r_cnt <= 0;
        end else if (r_cnt >= resp_lat - 1) begin
            r_cnt <= 0;
            r_ack <= want;
            if (phy_ctrl[16]) r_adr <= phy_ctrl[15:0];
            if (phy_ctrl[17]) r_dat <= phy_ctrl[15:0];
            if (phy_ctrl[18]) mem[r_adr[3:0]] <= r_dat;
            if (phy_ctrl[19]) r_rd <= mem[r_adr[3:0]];
        end else begin
            r_cnt <= r_cnt + 1;
        end
    end
    assign phy_stat = {r_ack, r_rd};

    // log of every change of the control word
    logic [19:0] log_v [512];
    int          log_n = 0;
    logic [19:0] last_c = '0;
    always @(negedge clk) begin
        if (rst_n && phy_ctrl != last_c) begin
            last_c <= phy_ctrl;
            if (log_n < 512) log_v[log_n] <= phy_ctrl;
            log_n <= log_n + 1;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    logic [19:0] exp_v [16];
    int          exp_n;
    logic [19:0] exp_last;

    function automatic void push(input logic [19:0] v);
        if (v != exp_last && exp_n < 16) begin
            exp_v[exp_n] = v;
            exp_n++;
            exp_last = v;
        end
    endfunction

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [15:0] exp_rd, input bit exp_err, input bit poke,
                          input string rq, output int cyc);
        int  base;
        bit  seq_ok;
        base = log_n;
        exp_n = 0;
        exp_last = '0;
        if (!exp_err) begin
            push({4'b0000, a}); push({4'b0001, a}); push({4'b0000, a});
            if (wr) begin
                push({4'b0000, d}); push({4'b0010, d}); push({4'b0000, d});
                push({4'b0100, 16'h0}); push({4'b0000, d}); push(20'h0);
            end else begin
                push({4'b1000, 16'h0}); push(20'h0);
            end
        end else if (resp_mode == 1) begin
            push({4'b0000, a}); push({4'b0001, a}); push(20'h0);
        end else begin
            push({4'b0000, a}); push({4'b0001, a}); push({4'b0000, a}); push(20'h0);
        end

        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        cyc = 1;
        while (!req_done && cyc < 3000) begin
            if (poke && cyc == 6) begin
                req_start = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
            end else begin
                req_start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_start = 1'b0;
        check(req_done == 1'b1, {rq, " done seen"}, 32'(req_done), 32'd1);
        check(req_err == exp_err, {rq, " R8 error flag"}, 32'(req_err), 32'(exp_err));
        check(phy_ctrl == '0, {rq, " R5 R8 ctrl zero at done"}, 32'(phy_ctrl), 32'd0);
        if (!wr && !exp_err)
            check(req_rdata == exp_rd, {rq, " R6 read data"}, 32'(req_rdata), 32'(exp_rd));
        @(negedge clk);
        check(req_done == 1'b0, {rq, " R5 done one cycle"}, 32'(req_done), 32'd0);
        // R3 R4 R5 R6 R10: complete control-word sequence, no extra changes
        seq_ok = ((log_n - base) == exp_n);
        for (int k = 0; k < exp_n; k++)
            if (seq_ok && log_v[base + k] != exp_v[k]) seq_ok = 0;
        check(seq_ok, {rq, " R3 R10 ctrl sequence"}, 32'(log_n - base), 32'(exp_n));
    endtask

    task automatic main_seq();
        int cyc;
        int n0;
        repeat (5) @(negedge clk);
        check(phy_ctrl == '0, "R1 ctrl in reset", 32'(phy_ctrl), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(phy_ctrl == '0, "R1 ctrl after reset", 32'(phy_ctrl), 32'd0);
        check(req_done == 1'b0, "R1 done after reset", 32'(req_done), 32'd0);
        check(req_err == 1'b0, "R1 err after reset", 32'(req_err), 32'd0);
        check(req_rdata == '0, "R1 rdata after reset", 32'(req_rdata), 32'd0);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 8; i++)
            run_op(VEC[i][48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], 1'b0, 1'b0, "R2 vector", cyc);

        // R7: slow acknowledge still inside the poll window
        resp_lat = 35;
        run_op(1'b1, 16'h100D, 16'h0BEE, 16'h0, 1'b0, 1'b0, "R7 slow write", cyc);
        run_op(1'b0, 16'h100D, 16'h0, 16'h0BEE, 1'b0, 1'b0, "R7 slow read", cyc);
        resp_lat = 3;

        // R8: acknowledge never rises, exact timeout edge, no commit
        resp_mode = 1;
        run_op(1'b1, 16'h0003, 16'h7777, 16'h0, 1'b1, 1'b0, "R8 no-rise", cyc);
        check(cyc == TMO_EDGES, "R8 timeout edge count", 32'(cyc), 32'(TMO_EDGES));
        resp_mode = 0;
        repeat (10) @(negedge clk);
        run_op(1'b0, 16'h0003, 16'h0, 16'h1234, 1'b0, 1'b0, "R8 no commit after timeout", cyc);

        // R8: acknowledge never falls
        resp_mode = 2;
        run_op(1'b0, 16'h1005, 16'h0, 16'h0, 1'b1, 1'b0, "R8 no-fall", cyc);
        resp_mode = 0;
        repeat (10) @(negedge clk);
        run_op(1'b0, 16'h1005, 16'h0, 16'h0028, 1'b0, 1'b0, "R8 recovery read", cyc);

        // R9: start pulse in the middle of an operation
        run_op(1'b1, 16'h0003, 16'h5A5A, 16'h0, 1'b0, 1'b1, "R9 poke write", cyc);
        n0 = log_n;
        repeat (20) @(negedge clk);
        check(log_n == n0 && phy_ctrl == '0, "R9 nothing started after", 32'(log_n - n0), 32'd0);
        run_op(1'b0, 16'h0003, 16'h0, 16'h5A5A, 1'b0, 1'b0, "R9 original data kept", cyc);
        run_op(1'b0, 16'hFFFC, 16'h0, 16'h0000, 1'b0, 1'b0, "R9 poked address untouched", cyc);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule